// File: doc/BRIEF.md
# Multi-Comparator Event Timer

The block is a memory-mapped event timer. One 64-bit main counter runs freely while a global enable is set. A parameterised set of comparators watches that counter. Each comparator runs in one-shot or periodic mode and drives its own interrupt line, either as a level held by a status bit or as a single-cycle pulse. Software reaches every register over a simple word-addressed bus: 32-bit data, a write strobe and a combinational read path. A 64-bit quantity is split into two 32-bit halves.

A periodic comparator keeps its next expiry time in an accumulator and its interval in a separate period register, so the main counter is never disturbed. Each comparator has an arming state machine with three states. `ARM_IDLE` is normal operation. `ARM_FIRST` means the next compare writes target the accumulator. `ARM_PERIOD` means the next compare writes target the period.

Each low-half compare write advances the machine by one step. High-half writes only land in the register that the current state selects. The transitions are:
- *arm*: `ARM_IDLE` to `ARM_FIRST`, on a configuration write with both periodic and value-set set, on a periodic-capable timer;
- *first-loaded*: `ARM_FIRST` to `ARM_PERIOD`, on a low compare write;
- *period-loaded*: `ARM_PERIOD` to `ARM_IDLE`, on a low compare write;
- *abort*: any arming state to `ARM_IDLE`, on a configuration write that clears periodic mode.

Top module: `evt_timer_top`

## Requirements
- R1: Address 0 reads timers-1 in bits 12:8, a 1 in bit 13 (64-bit counter) and 1 in bits 7:0. Address 1 reads the counter tick period in femtoseconds.
- R2: The counter resets to 0. It advances by one per clock only while bit 0 of the global configuration word (address 2) is 1.
- R3: Counter writes to address 4 (low half) or address 5 (high half) take effect only while counting is disabled. While counting is enabled they are ignored.
- R4: In one-shot mode, the cycle in which the counter equals the compare value is a match. The timer's status bit and level interrupt are set on the following clock edge.
- R5: A one-shot timer does not fire again as the counter moves on. It fires again after its compare value is rewritten to a value the counter will reach.
- R6: In periodic mode, writing the configuration with value-set (bit 4) and periodic (bit 2) set arms the timer. The next low compare write sets the first expiry, and the one after sets the period. The timer then fires at first, first+P, first+2P, and so on.
- R7: The value-set bit reads 1 while arming is in progress and reads 0 once the period is loaded.
- R8: Configuration bit 3 reads 1 only on periodic-capable timers (default: all but the last). On other timers a write of bit 2 is ignored and bit 2 reads 0.
- R9: In the status word (address 3), bit n belongs to timer n and is set by a level-mode match. Writing 1 clears the bit; writing 0 leaves it unchanged.
- R10: An interrupt line is asserted only when the timer's enable bit (bit 1) is set. A level-mode match still sets the status bit when that enable is clear.
- R11: In edge mode (bit 0 = 0), a match with the interrupt enabled gives a one-cycle pulse on the line and leaves the status bit clear.
- R12: With bit 5 set, a timer matches on the low 32 bits of the counter and compare value only.
- R13: Each 64-bit register is two 32-bit halves: the low half at the even word, the high half at the next word. A write to one half leaves the other half unchanged. Timer n sits at word 8+4n: configuration at +0, compare low at +2, compare high at +3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | NUM_TMR | One interrupt line per timer |

## Verification
Reads are combinational, so a value read in the middle of a cycle shows the state after the latest edge. A write lands on the first edge at which it is presented.

After counting is enabled at edge E, the counter holds k between edges E+k and E+k+1. A match on value C therefore shows as a status bit, a level interrupt or an edge pulse at the edge E+C+1.

The bench counts clock edges from the enabling write and samples on falling edges. It compares each observed delay against this C+1 rule, including the periodic C+P+1 and C+2P+1 cases and a compare rewrite relative to a counter value it has just read.

// File: rtl/evt_pkg.sv
package evt_pkg;
    // timer configuration bit positions
    localparam int CFG_LVL  = 0;
    localparam int CFG_IE   = 1;
    localparam int CFG_PER  = 2;
    localparam int CFG_PCAP = 3;
    localparam int CFG_VS   = 4;
    localparam int CFG_F32  = 5;

    // word address map
    localparam int A_CAP_LO     = 0;
    localparam int A_CAP_HI     = 1;
    localparam int A_GCFG       = 2;
    localparam int A_STS        = 3;
    localparam int A_CNT_LO     = 4;
    localparam int A_CNT_HI     = 5;
    localparam int A_TMR_BASE   = 8;
    localparam int A_TMR_STRIDE = 4;
    localparam int T_CFG        = 0;
    localparam int T_CMP_LO     = 2;
    localparam int T_CMP_HI     = 3;

    typedef enum logic [1:0] {
        ARM_IDLE   = 2'd0,
        ARM_FIRST  = 2'd1,
        ARM_PERIOD = 2'd2
    } arm_state_t;
endpackage

// File: rtl/evt_main_cnt.sv
module evt_main_cnt #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt
);
    localparam int HALF = CNT_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end else begin
            if (wr_lo) cnt[HALF-1:0]     <= wdata[HALF-1:0];
            if (wr_hi) cnt[CNT_W-1:HALF] <= wdata[HALF-1:0];
        end
    end

    // R2: advances by exactly one per enabled cycle
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt == $past(cnt) + 1'b1);

    // R3: holds when disabled and not written
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/evt_comparator.sv
module evt_comparator
    import evt_pkg::*;
#(
    parameter bit CAN_PER = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_en,
    input  logic [63:0] cnt,
    input  logic        cfg_we,
    input  logic        cmp_we_lo,
    input  logic        cmp_we_hi,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_rd,
    output logic [63:0] cmp_rd,
    output logic        hit,
    output logic        lvl_mode,
    output logic        int_en
);
    arm_state_t  state, state_nx;
    logic        lvl, ie, per, f32;
    logic [63:0] cmp, period;
    logic        match, tgt_acc, tgt_per, per_wr;
    logic [63:0] adv, adv_eff;

    assign per_wr = wdata[CFG_PER] & CAN_PER;

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ARM_IDLE:   if (cfg_we && per_wr && wdata[CFG_VS]) state_nx = ARM_FIRST;
            ARM_FIRST:  if (cfg_we && !per_wr)                 state_nx = ARM_IDLE;
                        else if (cmp_we_lo)                    state_nx = ARM_PERIOD;
            ARM_PERIOD: if (cfg_we && !per_wr)                 state_nx = ARM_IDLE;
                        else if (cmp_we_lo)                    state_nx = ARM_IDLE;
            default:                                           state_nx = ARM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARM_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath steered by the state
    assign tgt_acc = (state == ARM_FIRST)  || (state == ARM_IDLE && !per);
    assign tgt_per = (state == ARM_PERIOD) || (state == ARM_IDLE && per);
    assign match   = f32 ? (cnt[31:0] == cmp[31:0]) : (cnt == cmp);
    assign hit     = cnt_en && match && (state == ARM_IDLE);
    assign adv     = cmp + period;
    assign adv_eff = f32 ? {cmp[63:32], adv[31:0]} : adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= 1'b0; ie <= 1'b0; per <= 1'b0; f32 <= 1'b0;
            cmp <= '0;   period <= '0;
        end else begin
            if (cfg_we) begin
                lvl <= wdata[CFG_LVL];
                ie  <= wdata[CFG_IE];
                per <= per_wr;
                f32 <= wdata[CFG_F32];
            end
            if (tgt_acc && (cmp_we_lo || cmp_we_hi)) begin
                if (cmp_we_lo) cmp[31:0]  <= wdata;
                if (cmp_we_hi) cmp[63:32] <= wdata;
            end else if (hit && per) begin
                cmp <= adv_eff;
            end
            if (tgt_per && cmp_we_lo) period[31:0]  <= wdata;
            if (tgt_per && cmp_we_hi) period[63:32] <= wdata;
        end
    end

    assign cfg_rd   = {26'd0, f32, (state != ARM_IDLE), CAN_PER, per, ie, lvl};
    assign cmp_rd   = cmp;
    assign lvl_mode = lvl;
    assign int_en   = ie;

    // R6: arming only happens with periodic mode held
    p_arm_needs_per_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ARM_IDLE) |-> per);

    // R6: accumulator advances by the period on each periodic match
    p_acc_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && per && !f32) |=> cmp == $past(cmp) + $past(period));
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
    import evt_pkg::*;
#(
    parameter int                    NUM_TMR      = 3,
    parameter logic [31:0]           PERIOD_FS    = 32'd10_000_000,
    parameter logic [NUM_TMR-1:0]    PER_CAP_MASK = 3'b011,
    parameter int                    ADDR_W       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_TMR-1:0] irq_o
);
    localparam logic [4:0]  TMR_M1   = 5'(NUM_TMR - 1);
    localparam logic [31:0] CAP_LO_W = {18'd0, 1'b1, TMR_M1, 8'h01};

    logic               g_en;
    logic [63:0]        cnt;
    logic [NUM_TMR-1:0] sts, pulse, hit, lvl, ie;
    logic [31:0]        cfg_rd [NUM_TMR];
    logic [63:0]        cmp_rd [NUM_TMR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                           g_en <= 1'b0;
        else if (bus_we && bus_addr == ADDR_W'(A_GCFG))       g_en <= bus_wdata[0];
    end

    evt_main_cnt #(.CNT_W(64)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (g_en),
        .wr_lo (bus_we && bus_addr == ADDR_W'(A_CNT_LO)),
        .wr_hi (bus_we && bus_addr == ADDR_W'(A_CNT_HI)),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam int BASE = A_TMR_BASE + A_TMR_STRIDE * t;
        logic w1c;

        evt_comparator #(.CAN_PER(PER_CAP_MASK[t])) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_en    (g_en),
            .cnt       (cnt),
            .cfg_we    (bus_we && bus_addr == ADDR_W'(BASE + T_CFG)),
            .cmp_we_lo (bus_we && bus_addr == ADDR_W'(BASE + T_CMP_LO)),
            .cmp_we_hi (bus_we && bus_addr == ADDR_W'(BASE + T_CMP_HI)),
            .wdata     (bus_wdata),
            .cfg_rd    (cfg_rd[t]),
            .cmp_rd    (cmp_rd[t]),
            .hit       (hit[t]),
            .lvl_mode  (lvl[t]),
            .int_en    (ie[t])
        );

        assign w1c = bus_we && bus_addr == ADDR_W'(A_STS) && bus_wdata[t];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts[t]   <= 1'b0;
                pulse[t] <= 1'b0;
            end else begin
                if (hit[t] && lvl[t]) sts[t] <= 1'b1;
                else if (w1c)         sts[t] <= 1'b0;
                pulse[t] <= hit[t] && ie[t] && !lvl[t];
            end
        end

        assign irq_o[t] = lvl[t] ? (sts[t] && ie[t]) : pulse[t];

        // R9: status only falls through a write-1 clear
        p_sts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[t] && !w1c) |=> sts[t]);

        // R4: a level-mode match is recorded on the next edge
        p_level_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[t] && lvl[t]) |=> sts[t]);

        // R11: an edge-mode pulse lasts one cycle unless another match follows
        p_edge_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[t] && !lvl[t] && !hit[t]) |=> !irq_o[t]);

        // R10: no interrupt while the timer's enable was clear at the match
        p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[t] && !ie[t] && !lvl[t] && !bus_we) |=> !irq_o[t]);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CAP_LO)) bus_rdata = CAP_LO_W;
        if (bus_addr == ADDR_W'(A_CAP_HI)) bus_rdata = PERIOD_FS;
        if (bus_addr == ADDR_W'(A_GCFG))   bus_rdata = {31'd0, g_en};
        if (bus_addr == ADDR_W'(A_STS))    bus_rdata = 32'(sts);
        if (bus_addr == ADDR_W'(A_CNT_LO)) bus_rdata = cnt[31:0];
        if (bus_addr == ADDR_W'(A_CNT_HI)) bus_rdata = cnt[63:32];
        for (int t = 0; t < NUM_TMR; t++) begin
            if (bus_addr == ADDR_W'(A_TMR_BASE + A_TMR_STRIDE * t + T_CFG))
                bus_rdata = cfg_rd[t];
            if (bus_addr == ADDR_W'(A_TMR_BASE + A_TMR_STRIDE * t + T_CMP_LO))
                bus_rdata = cmp_rd[t][31:0];
            if (bus_addr == ADDR_W'(A_TMR_BASE + A_TMR_STRIDE * t + T_CMP_HI))
                bus_rdata = cmp_rd[t][63:32];
        end
    end
endmodule

// File: tb/sim_evt_timer_top.sv
module sim_evt_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_o;

    int nchk = 0, nfail = 0, cyc = 0, t0 = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    evt_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_irq(int idx, int lim, output int dt);
        dt = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq_o[idx]) begin
                dt = cyc - t0;
                break;
            end
        end
    endtask

    task automatic start_cnt();
        wr(2, 1);
        t0 = cyc;
    endtask

    initial begin
        logic [31:0] v, w;
        int dt, highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state, capability word
        rd(0, v); chk("R1 cap low", v, 32'h2201);
        rd(1, v); chk("R1 cap period", v, 32'd10_000_000);
        rd(4, v); chk("R2 counter at reset", v, 0);
        rd(3, v); chk("R9 status at reset", v, 0);
        chk("R10 irq at reset", irq_o, 0);

        // R2: idle while disabled, steps by one once enabled
        repeat (5) @(negedge clk);
        rd(4, v); chk("R2 no count while disabled", v, 0);
        start_cnt();
        rd(4, v); rd(4, w); chk("R2 step per cycle", w, v + 1);

        // R3: writes ignored while counting
        wr(5, 32'h55);
        rd(5, v); chk("R3 hi write ignored while enabled", v, 0);
        wr(2, 0);
        rd(4, w);
        wr(5, 32'h55);
        rd(5, v); chk("R3 hi write while disabled", v, 32'h55);
        rd(4, v); chk("R13 lo half untouched", v, w);
        wr(4, 0); wr(5, 0);

        // R8: periodic capability
        wr(16, 32'h4);
        rd(16, v); chk("R8 periodic ignored on timer2", v, 0);
        rd(8, v); chk("R8 timer0 reports capable", v, 32'h8);

        // R6/R7: periodic arming and firing
        wr(8, 32'h17);
        rd(8, v); chk("R7 value-set while arming", v, 32'h1F);
        wr(10, 10);
        rd(8, v); chk("R7 value-set after first expiry", v, 32'h1F);
        wr(10, 7);
        rd(8, v); chk("R7 value-set clears after period", v, 32'h0F);
        start_cnt();
        wait_irq(0, 40, dt); chk("R6 first expiry", dt, 11);
        wr(3, 1);
        wait_irq(0, 40, dt); chk("R6 first plus one period", dt, 18);
        wr(3, 1);
        wait_irq(0, 40, dt); chk("R6 first plus two periods", dt, 25);
        wr(2, 0); wr(8, 0); wr(3, 32'h7);

        // R4/R5: one-shot
        wr(4, 0); wr(12, 32'h3); wr(14, 30);
        start_cnt();
        wait_irq(1, 60, dt); chk("R4 one-shot match", dt, 31);
        rd(3, v); chk("R9 status bit 1 set", v, 32'h2);
        wr(3, 32'h2);
        rd(3, v); chk("R9 write-1 clears", v, 0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq_o[1]) highs++;
        end
        chk("R5 no refire without rewrite", highs, 0);
        rd(4, v);
        t0 = cyc;
        wr(14, v + 10);
        wait_irq(1, 40, dt); chk("R5 refire after rewrite", dt, 11);
        wr(2, 0); wr(3, 32'h7);

        // R11: edge mode pulse
        wr(4, 0); wr(12, 32'h2); wr(14, 5);
        start_cnt();
        wait_irq(1, 40, dt); chk("R11 pulse time", dt, 6);
        @(negedge clk); chk("R11 pulse one cycle", irq_o[1], 0);
        rd(3, v); chk("R11 no status in edge mode", v, 0);
        wr(2, 0);

        // R10/R9: enable gating and write-0
        wr(4, 0); wr(12, 32'h1); wr(14, 4);
        start_cnt();
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (irq_o[1]) highs++;
        end
        chk("R10 no irq when disabled", highs, 0);
        rd(3, v); chk("R10 status still recorded", v, 32'h2);
        wr(3, 0);
        rd(3, v); chk("R9 write 0 no effect", v, 32'h2);
        wr(3, 32'h2);
        rd(3, v); chk("R9 clear", v, 0);
        wr(2, 0);

        // R12: 32-bit compare; 64-bit timer with same low half stays quiet
        wr(5, 5); wr(4, 20);
        wr(16, 32'h23); wr(18, 25); wr(19, 7);
        wr(8, 32'h3);   wr(10, 25); wr(11, 7);
        rd(19, v); chk("R13 compare hi half", v, 7);
        rd(18, v); chk("R13 compare lo half", v, 25);
        start_cnt();
        wait_irq(2, 40, dt); chk("R12 32-bit match", dt, 6);
        chk("R12 64-bit timer no match", irq_o[0], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule